// File: doc/BRIEF.md
# Shift-Chain Synchronous FIFO

A single-clock first-in first-out buffer whose storage is a chain of registers rather than an addressed memory. Every accepted write enters at cell 0 and pushes all older entries one cell further along the chain. Because of this, the oldest entry always sits at the far end of the occupied part of the chain. An output multiplexer selects that cell, and a single pointer drives its select. The pointer rises on a write, falls on a read, and holds when both or neither happen.

The block is meant for short, same-clock elasticity where a compact chain with one pointer is cheaper than a RAM with separate read and write addresses. The raw output is combinational from the chain, so both sides must be in one clock domain. An optional capture register samples the multiplexer output under its own enable, which is independent of shifting. The chain cells and the select pointer have no reset. Only the occupancy count and the empty flag are reset.

Top module: `srFifo`

## Requirements
- R1: After reset `isEmpty` is 1, `isFull` is 0 and `level` is 0.
- R2: A write (`loadEn`=1) while not full is accepted on the clock edge and raises `level` by one.
- R3: Whenever `isEmpty` is 0, `dataOut` equals the oldest accepted entry not yet read, in the same cycle and without a clock.
- R4: A read (`readEn`=1) while not empty removes the oldest entry on the clock edge and lowers `level` by one, so entries leave in write order.
- R5: `isFull` is 1 exactly when `level` is 16. A write without a read while full is ignored: `level`, `dataOut` and all stored entries stay unchanged.
- R6: A read without a write while empty is ignored. The FIFO stays empty, and a later write is the next entry read.
- R7: A simultaneous read and write while not empty, including while full, keeps `level` unchanged, removes the oldest entry and appends the new one.
- R8: A simultaneous read and write while empty accepts the write only, and `level` becomes 1.
- R9: On each clock edge where `outRegEn` is 1, `dataOutReg` takes the value `dataOut` had before that edge. While `outRegEn` is 0, `dataOutReg` holds, whatever the chain does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rstN | input | 1 | Active-low synchronous reset of control state |
| loadEn | input | 1 | Write strobe |
| dataIn | input | 8 | Write data |
| readEn | input | 1 | Read strobe |
| outRegEn | input | 1 | Enable for the output capture register |
| dataOut | output | 8 | Oldest entry, combinational |
| dataOutReg | output | 8 | Registered copy of dataOut |
| level | output | 5 | Number of stored entries |
| isFull | output | 1 | 16 entries stored |
| isEmpty | output | 1 | No entries stored |

## Verification
On every cycle, the assertions check the occupancy bookkeeping: a write refused at full, a read refused at empty, an unchanged level on a combined read and write, agreement between the empty flag and the count, and capture of input data into the first cell. Only the bench scenarios can show data ordering across a fill and drain. The same holds for the head value surviving an ignored write at full, the head advancing on a combined read and write at full, and the capture register holding while the chain keeps shifting.

// File: rtl/srFifoPkg.sv
package srFifoPkg;
  typedef struct packed {
    logic shiftEn;
    logic captureEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/srFifoCtrl.sv
module srFifoCtrl
  import srFifoPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadEn,
  input  logic          readEn,
  input  logic          outRegEn,
  output ctrlStrobes_t  strobes,
  output logic [PW-1:0] sel,
  output logic [CW-1:0] level,
  output logic          isFull,
  output logic          isEmpty
);
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptrNext;
  logic [CW-1:0] count;
  logic [CW-1:0] countNext;
  logic          emptyQ;
  logic          wrAcc;
  logic          rdAcc;

  assign isFull = (count == CW'(DEPTH));
  assign rdAcc  = readEn & ~emptyQ;
  assign wrAcc  = loadEn & (~isFull | rdAcc);

  always_comb begin
    if (emptyQ) ptrNext = '0;
    else        ptrNext = ptr + PW'(wrAcc) - PW'(rdAcc);
  end

  assign countNext = count + CW'(wrAcc) - CW'(rdAcc);

  // select pointer: storage-like, no reset
  always_ff @(posedge clk) begin
    if (wrAcc | rdAcc) ptr <= ptrNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      emptyQ <= 1'b1;
    end else begin
      count  <= countNext;
      emptyQ <= (countNext == '0);
    end
  end

  assign strobes.shiftEn   = wrAcc;
  assign strobes.captureEn = outRegEn;
  assign sel     = ptr;
  assign level   = count;
  assign isEmpty = emptyQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && loadEn && !readEn) |=> (count == $past(count))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (emptyQ && readEn && !loadEn) |=> emptyQ); // R6
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!emptyQ && readEn && loadEn) |=> (count == $past(count))); // R7
  AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (emptyQ && readEn && loadEn) |=> (count == CW'(1))); // R8
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    emptyQ == (count == '0)); // R1
endmodule

// File: rtl/srFifoData.sv
module srFifoData
  import srFifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter bit HAS_OUT_REG = 1'b1,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [PW-1:0]    sel,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] dataOutReg
);
  logic [WIDTH-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : gCell
    if (i == 0) begin : gHead
      always_ff @(posedge clk) if (strobes.shiftEn) cells[0] <= dataIn;
    end else begin : gBody
      always_ff @(posedge clk) if (strobes.shiftEn) cells[i] <= cells[i-1];
    end
  end

  assign dataOut = cells[sel];

  if (HAS_OUT_REG) begin : gOutReg
    logic [WIDTH-1:0] capQ;
    always_ff @(posedge clk) if (strobes.captureEn) capQ <= dataOut;
    assign dataOutReg = capQ;
  end else begin : gNoOutReg
    assign dataOutReg = dataOut;
  end

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> (cells[0] == $past(dataIn))); // R2
endmodule

// File: rtl/srFifo.sv
module srFifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter bit HAS_OUT_REG = 1'b1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             readEn,
  input  logic             outRegEn,
  output logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] dataOutReg,
  output logic [CW-1:0]    level,
  output logic             isFull,
  output logic             isEmpty
);
  srFifoPkg::ctrlStrobes_t strobes;
  logic [PW-1:0] sel;

  srFifoCtrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .readEn(readEn),
    .outRegEn(outRegEn), .strobes(strobes), .sel(sel),
    .level(level), .isFull(isFull), .isEmpty(isEmpty)
  );

  srFifoData #(.DEPTH(DEPTH), .WIDTH(WIDTH), .HAS_OUT_REG(HAS_OUT_REG)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sel(sel),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutReg(dataOutReg)
  );
endmodule

// File: tb/test_srFifo.sv
module test_srFifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [7:0] dataIn = '0;
  logic       readEn = 1'b0;
  logic       outRegEn = 1'b0;
  logic [7:0] dataOut;
  logic [7:0] dataOutReg;
  logic [4:0] level;
  logic       isFull;
  logic       isEmpty;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  logic [7:0] expReg;
  bit         expRegValid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srFifo i_srFifo (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .dataIn(dataIn),
    .readEn(readEn), .outRegEn(outRegEn), .dataOut(dataOut),
    .dataOutReg(dataOutReg), .level(level), .isFull(isFull), .isEmpty(isEmpty)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares design state against the scoreboard between edges
  task automatic monitor();
    int n = expQ.size();
    check(level == 5'(n), "R2/R4 level", int'(level), n);
    check(isEmpty == (n == 0), "R6 empty flag", int'(isEmpty), int'(n == 0));
    check(isFull == (n == DEPTH), "R5 full flag", int'(isFull), int'(n == DEPTH));
    if (n > 0) check(dataOut == expQ[0], "R3 head data", int'(dataOut), int'(expQ[0]));
    if (expRegValid) check(dataOutReg == expReg, "R9 output register", int'(dataOutReg), int'(expReg));
  endtask

  // driver: applies one cycle and updates the scoreboard
  task automatic cycle(input bit ld, input logic [7:0] d, input bit rd, input bit oe);
    logic [7:0] headBefore;
    bit wasEmpty, wasFull, rdOk, wrOk;
    @(negedge clk);
    loadEn = ld; dataIn = d; readEn = rd; outRegEn = oe;
    #2;
    monitor();
    wasEmpty = (expQ.size() == 0);
    wasFull = (expQ.size() == DEPTH);
    headBefore = wasEmpty ? 8'h00 : expQ[0];
    rdOk = rd && !wasEmpty;
    wrOk = ld && (!wasFull || rdOk);
    @(posedge clk);
    #1;
    if (oe && !wasEmpty) begin expReg = headBefore; expRegValid = 1'b1; end
    else if (oe) expRegValid = 1'b0;
    if (rdOk) void'(expQ.pop_front());
    if (wrOk) expQ.push_back(d);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    if (!done) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    // R1 reset state
    check(isEmpty == 1'b1, "R1 empty after reset", int'(isEmpty), 1);
    check(isFull == 1'b0, "R1 full after reset", int'(isFull), 0);
    check(level == 5'd0, "R1 level after reset", int'(level), 0);

    // R6 read on empty ignored
    cycle(0, 8'h00, 1, 0);
    cycle(0, 8'h00, 1, 0);
    // R8 simultaneous on empty
    cycle(1, 8'hA5, 1, 0);
    cycle(0, 8'h00, 0, 0);
    // R2/R3/R4 ordered writes then reads
    for (int i = 0; i < 5; i++) cycle(1, 8'(8'h10 + i), 0, 0);
    for (int i = 0; i < 6; i++) cycle(0, 8'h00, 1, 0);
    cycle(0, 8'h00, 1, 0); // R6 extra read on empty
    // R5 fill to full
    for (int i = 0; i < DEPTH; i++) cycle(1, 8'(8'h40 + i * 3), 0, 0);
    // R5 writes while full ignored
    for (int i = 0; i < 3; i++) cycle(1, 8'hEE, 0, 0);
    // R7 simultaneous at full
    for (int i = 0; i < 4; i++) cycle(1, 8'(8'hC0 + i), 1, 0);
    // R9 capture while draining, then hold while shifting
    cycle(0, 8'h00, 1, 1);
    cycle(0, 8'h00, 1, 1);
    for (int i = 0; i < 4; i++) cycle(1, 8'(8'h70 + i), 1, 0);
    cycle(0, 8'h00, 0, 1);
    // R7 simultaneous mid-level, interleaved pattern
    for (int i = 0; i < 10; i++) cycle(1, 8'(8'h90 + i), i[0], 0);
    // drain completely
    for (int i = 0; i < DEPTH + 2; i++) cycle(0, 8'h00, 1, 0);
    cycle(0, 8'h00, 0, 0);
    @(negedge clk); #2; monitor();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule